// File: doc/BRIEF.md
# Error Snapshot Capture and Lock Register

This block sits beside a host bridge's bus interface. It takes a set of live status values each cycle: the bus command and its dual-address flag, the target and master state-machine codes, a one-hot address window hit vector, and the DMA command and its dual-address flag. It packs them into a 32-bit read-only diagnostic word. While no error is pending, the word follows the live status. An error strobe from the memory side (ECC, nonexistent memory, bad page table entry) or from the bus side (parity, aborts, I/O timeout) records its status bit and freezes the word on the same clock edge.

The word stays frozen until software clears every pending status bit. It does this with write-one-to-clear accesses to the error status word. That word also carries a lock flag, so software can tell whether the snapshot is valid. The block does not decode addresses, run state machines or detect errors. It only records what it is given.

Two register addresses are visible through a single-cycle port. Address 0 is the error status word. Address 1 is the snapshot. Reads are combinational on the address.

Top module: `err_capture_lock`

## Requirements
- R1: While reset is asserted, both the status word (address 0) and the snapshot (address 1) read as zero.
- R2: The snapshot places the bus dual-address flag at bit 28, the bus command at 27:24, the target state at 23:20, the master state at 19:16, the window hit at 11:8, the DMA dual-address flag at bit 5 and the DMA command at 3:0. All other bits read zero.
- R3: While unlocked, the snapshot equals the live inputs sampled at the most recent clock edge.
- R4: A strobe on status position 0, 1, 3, 5, 6, 7, 8, 9 or 11 sets that status bit and the lock. The snapshot keeps the live values of that same edge.
- R5: While locked, the snapshot does not change, whatever the live inputs do. Further strobes set their status bits without touching the snapshot.
- R6: Strobes on positions 2, 4 and 10 have no effect: they set no status bit and no lock.
- R7: Writing 1 to a status bit at address 0 clears it, and writing 0 leaves it. Once the last set bit is cleared, the lock reads 0 from the next cycle on and tracking resumes.
- R8: If a strobe and a clear of the same bit land in one cycle, the bit stays set and the lock stays set.
- R9: The lock flag reads at bit 31 of the status word. Bits 30:12 and the unused positions read zero.
- R10: Writes to the snapshot address, and writes to status bit 31, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busDac | input | 1 | Live bus dual-address flag |
| busCmd | input | 4 | Live bus command |
| tgtState | input | 4 | Live target state code |
| mstState | input | 4 | Live master state code |
| winHit | input | 4 | Live one-hot window hit (0 = no window) |
| dmaDac | input | 1 | Live DMA dual-address flag |
| dmaCmd | input | 4 | Live DMA command |
| errEvt | input | 12 | Error strobes, one per status position |
| regWe | input | 1 | Register write enable |
| regAddr | input | 1 | Register select: 0 status, 1 snapshot |
| regWdata | input | 32 | Write data (ones clear status bits) |
| regRdata | output | 32 | Read data for the selected register |

## Verification
If the lock is wrongly set or dropped, the fault shows at address 0, bit 31, one cycle after the edge that caused it. It also shows at address 1: the snapshot either freezes early or keeps tracking while it should hold. A corrupted status bit is visible at address 0 after a single edge. A wrong field placement shows on the first read of the snapshot after live values change. Same-cycle collisions of a strobe and a clear show up at the status word one edge later.

// File: rtl/err_snap_pkg.sv
package err_snap_pkg;
  localparam int WORD_W = 32;
  localparam int STS_W = 12;
  localparam logic [STS_W-1:0] ERR_SRC_MASK = 12'hBEB;
  localparam int LOCK_POS = 31;

  // snapshot field positions
  localparam int BUS_DAC_POS = 28;
  localparam int BUS_CMD_LSB = 24;
  localparam int TGT_LSB = 20;
  localparam int MST_LSB = 16;
  localparam int WIN_LSB = 8;
  localparam int DMA_DAC_POS = 5;
  localparam int DMA_CMD_LSB = 0;
  localparam int FIELD_W = 4;

  typedef struct packed {
    logic trackEn;
    logic lockState;
  } ctrlStrb_t;
endpackage

// File: rtl/err_snap_ctrl.sv
module err_snap_ctrl
  import err_snap_pkg::*;
#(
  parameter logic [STS_W-1:0] SRC_MASK = ERR_SRC_MASK
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [STS_W-1:0] errEvt,
  input  logic             stsWrite,
  input  logic [STS_W-1:0] clrBits,
  output logic [STS_W-1:0] stsQ,
  output ctrlStrb_t        strb
);
  logic [STS_W-1:0] clrMask;
  logic [STS_W-1:0] newErr;
  logic [STS_W-1:0] stsNext;
  logic             lockQ;

  always_comb begin
    clrMask = stsWrite ? clrBits : '0;
    newErr  = errEvt & SRC_MASK;
    stsNext = (stsQ & ~clrMask) | newErr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stsQ  <= '0;
      lockQ <= 1'b0;
    end else begin
      stsQ  <= stsNext;
      lockQ <= |stsNext;
    end
  end

  always_comb begin
    strb.trackEn   = !lockQ;
    strb.lockState = lockQ;
  end
endmodule

// File: rtl/err_snap_dp.sv
module err_snap_dp
  import err_snap_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic               busDac,
  input  logic [FIELD_W-1:0] busCmd,
  input  logic [FIELD_W-1:0] tgtState,
  input  logic [FIELD_W-1:0] mstState,
  input  logic [FIELD_W-1:0] winHit,
  input  logic               dmaDac,
  input  logic [FIELD_W-1:0] dmaCmd,
  output logic [WORD_W-1:0]  liveWord,
  output logic [WORD_W-1:0]  snapQ
);
  always_comb begin
    liveWord = '0;
    liveWord[BUS_DAC_POS]                     = busDac;
    liveWord[BUS_CMD_LSB +: FIELD_W]          = busCmd;
    liveWord[TGT_LSB +: FIELD_W]              = tgtState;
    liveWord[MST_LSB +: FIELD_W]              = mstState;
    liveWord[WIN_LSB +: FIELD_W]              = winHit;
    liveWord[DMA_DAC_POS]                     = dmaDac;
    liveWord[DMA_CMD_LSB +: FIELD_W]          = dmaCmd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             snapQ <= '0;
    else if (strb.trackEn) snapQ <= liveWord;
  end
endmodule

// File: rtl/err_capture_lock.sv
module err_capture_lock
  import err_snap_pkg::*;
#(
  parameter logic [STS_W-1:0] SRC_MASK = ERR_SRC_MASK
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busDac,
  input  logic [3:0]  busCmd,
  input  logic [3:0]  tgtState,
  input  logic [3:0]  mstState,
  input  logic [3:0]  winHit,
  input  logic        dmaDac,
  input  logic [3:0]  dmaCmd,
  input  logic [11:0] errEvt,
  input  logic        regWe,
  input  logic        regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata
);
  localparam int PAD_W = LOCK_POS - STS_W;

  ctrlStrb_t         strb;
  logic [STS_W-1:0]  stsQ;
  logic [WORD_W-1:0] snapQ;
  logic [WORD_W-1:0] liveWord;
  logic              stsWrite;
  logic              lockQ;

  assign stsWrite = regWe && (regAddr == 1'b0);
  assign lockQ    = strb.lockState;

  err_snap_ctrl #(.SRC_MASK(SRC_MASK)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .errEvt   (errEvt),
    .stsWrite (stsWrite),
    .clrBits  (regWdata[STS_W-1:0]),
    .stsQ     (stsQ),
    .strb     (strb)
  );

  err_snap_dp dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busDac   (busDac),
    .busCmd   (busCmd),
    .tgtState (tgtState),
    .mstState (mstState),
    .winHit   (winHit),
    .dmaDac   (dmaDac),
    .dmaCmd   (dmaCmd),
    .liveWord (liveWord),
    .snapQ    (snapQ)
  );

  always_comb begin
    if (regAddr) regRdata = snapQ;
    else         regRdata = {lockQ, {PAD_W{1'b0}}, stsQ};
  end
endmodule

module err_capture_lock_chk
  import err_snap_pkg::*;
#(
  parameter logic [STS_W-1:0] SRC_MASK = ERR_SRC_MASK
) (
  input logic              clk,
  input logic              rstN,
  input logic [11:0]       errEvt,
  input logic              regWe,
  input logic              regAddr,
  input logic [31:0]       regWdata,
  input logic              lockQ,
  input logic [STS_W-1:0]  stsQ,
  input logic [WORD_W-1:0] snapQ,
  input logic [WORD_W-1:0] liveWord
);
  AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> $stable(snapQ)); // R5

  AST_TRACK_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    !lockQ |=> snapQ == $past(liveWord)); // R3

  AST_ERR_SETS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (|(errEvt & SRC_MASK)) |=> lockQ && ((stsQ & $past(errEvt & SRC_MASK)) == $past(errEvt & SRC_MASK))); // R4

  AST_IGNORED_SRC: assert property (@(posedge clk) disable iff (!rstN)
    (errEvt & ~SRC_MASK) != '0 && !lockQ && (errEvt & SRC_MASK) == '0 |=> !lockQ); // R6

  AST_FULL_CLEAR_UNLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    regWe && !regAddr && ((stsQ & ~regWdata[STS_W-1:0]) == '0) && ((errEvt & SRC_MASK) == '0) |=> !lockQ); // R7

  AST_SNAP_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    regWe && regAddr && lockQ |=> $stable(snapQ)); // R10
endmodule

bind err_capture_lock err_capture_lock_chk #(.SRC_MASK(SRC_MASK)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .errEvt   (errEvt),
  .regWe    (regWe),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .lockQ    (lockQ),
  .stsQ     (stsQ),
  .snapQ    (snapQ),
  .liveWord (liveWord)
);

// File: tb/err_capture_lock_tb.sv
module err_capture_lock_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busDac = 1'b0;
  logic [3:0]  busCmd = '0, tgtState = '0, mstState = '0, winHit = '0, dmaCmd = '0;
  logic        dmaDac = 1'b0;
  logic [11:0] errEvt = '0;
  logic        regWe = 1'b0;
  logic        regAddr = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;

  int applied = 0;
  int miscomp = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  always #5 clk = ~clk;

  err_capture_lock dut_i (
    .clk(clk), .rstN(rstN), .busDac(busDac), .busCmd(busCmd), .tgtState(tgtState),
    .mstState(mstState), .winHit(winHit), .dmaDac(dmaDac), .dmaCmd(dmaCmd),
    .errEvt(errEvt), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata)
  );

  // expected snapshot from the R2 field layout
  function automatic logic [31:0] packSnap(logic bd, logic [3:0] bc, logic [3:0] ts,
                                           logic [3:0] ms, logic [3:0] wh, logic dd,
                                           logic [3:0] dc);
    return {3'b000, bd, bc, ts, ms, 4'b0000, wh, 2'b00, dd, 1'b0, dc};
  endfunction

  function automatic logic [31:0] curLive();
    return packSnap(busDac, busCmd, tgtState, mstState, winHit, dmaDac, dmaCmd);
  endfunction

  task automatic setLive(logic bd, logic [3:0] bc, logic [3:0] ts, logic [3:0] ms,
                         logic [3:0] wh, logic dd, logic [3:0] dc);
    busDac = bd; busCmd = bc; tgtState = ts; mstState = ms;
    winHit = wh; dmaDac = dd; dmaCmd = dc;
  endtask

  // driver: select a register and hand the expected value to the scoreboard
  task automatic expectRd(logic a, logic [31:0] exp, string tag);
    item_t it;
    @(negedge clk);
    regAddr = a;
    it.exp = exp;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic wr(logic a, logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic strobe(logic [11:0] e);
    @(negedge clk);
    errEvt = e;
    @(negedge clk);
    errEvt = '0;
  endtask

  // monitor: compare after the read data has settled
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        applied++;
        if (regRdata !== it.exp) begin
          miscomp++;
          $display("FAIL %s: actual %h expected %h", it.tag, regRdata, it.exp);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      miscomp++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
      $finish;
    end
  end

  localparam logic [31:0] LK = 32'h8000_0000;

  initial begin
    logic [31:0] held;
    setLive(1'b1, 4'h7, 4'h3, 4'h4, 4'h2, 1'b1, 4'hC);
    // R1: reset values with live inputs nonzero
    expectRd(1'b0, 32'h0, "R1 status in reset");
    expectRd(1'b1, 32'h0, "R1 snapshot in reset");
    @(negedge clk);
    rstN = 1'b1;

    // R2/R3: tracking while unlocked
    expectRd(1'b1, curLive(), "R2 field layout");
    setLive(1'b0, 4'hB, 4'h9, 4'hA, 4'h8, 1'b0, 4'h6);
    expectRd(1'b1, curLive(), "R3 follows live");
    setLive(1'b1, 4'hF, 4'hF, 4'hF, 4'hF, 1'b1, 4'hF);
    expectRd(1'b1, 32'h1FFF_0F2F, "R2 reserved zero");

    // R4: memory-side error captures live values of that edge
    setLive(1'b1, 4'h6, 4'h2, 4'h5, 4'h1, 1'b0, 4'hE);
    held = curLive();
    @(negedge clk);
    errEvt = 12'h001;
    @(negedge clk);
    errEvt = '0;
    setLive(1'b0, 4'h1, 4'h0, 4'h0, 4'h4, 1'b1, 4'h3);
    expectRd(1'b0, LK | 32'h001, "R4 R9 status and lock");
    expectRd(1'b1, held, "R4 snapshot captured");

    // R5: later bus-side error while locked
    setLive(1'b1, 4'h2, 4'h7, 4'h9, 4'h8, 1'b1, 4'h1);
    strobe(12'h080);
    expectRd(1'b0, LK | 32'h081, "R5 later error sets bit");
    expectRd(1'b1, held, "R5 snapshot held");

    // R7: partial clear keeps the lock
    wr(1'b0, 32'h0000_0001);
    expectRd(1'b0, LK | 32'h080, "R7 partial clear");
    expectRd(1'b1, held, "R7 still frozen");

    // R10: writes to snapshot and to lock bit ignored
    wr(1'b0, 32'h8000_0000);
    expectRd(1'b0, LK | 32'h080, "R10 lock bit write");
    wr(1'b1, 32'hFFFF_FFFF);
    expectRd(1'b1, held, "R10 snapshot write");

    // R8: strobe and clear of the same bit in one cycle
    @(negedge clk);
    errEvt = 12'h080; regWe = 1'b1; regAddr = 1'b0; regWdata = 32'h080;
    @(negedge clk);
    errEvt = '0; regWe = 1'b0; regWdata = '0;
    expectRd(1'b0, LK | 32'h080, "R8 error wins");

    // R7: full clear releases lock, tracking resumes
    wr(1'b0, 32'h0000_0FFF);
    expectRd(1'b0, 32'h0, "R7 lock dropped");
    expectRd(1'b1, curLive(), "R7 tracking resumes");

    // R6: unused positions ignored
    strobe(12'h414);
    expectRd(1'b0, 32'h0, "R6 no status");
    setLive(1'b0, 4'h3, 4'h6, 4'h2, 4'h0, 1'b0, 4'h9);
    expectRd(1'b1, curLive(), "R6 no lock");

    // R4: each valid source sets its own bit
    for (int b = 0; b < 12; b++) begin
      if (b != 2 && b != 4 && b != 10) begin
        strobe(12'(1) << b);
        expectRd(1'b0, LK | (32'(1) << b), $sformatf("R4 source bit %0d", b));
        wr(1'b0, 32'(1) << b);
        expectRd(1'b0, 32'h0, $sformatf("R7 clear bit %0d", b));
      end
    end

    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
    $finish;
  end
endmodule